// File: doc/BRIEF.md
# Accumulator Processor Core, 8-bit

This block is a small non-pipelined 8-bit processor built around one accumulator (AC), one compare flag (F) and a bank of sixteen 8-bit registers. Instructions are 16 bits wide and come from a program memory. Data words are 8 bits wide and live in a separate data memory. Each memory has a 12-bit address. Both memories sit outside the core and behave as synchronous RAMs: read data appears in the cycle after the address is presented, and a write takes effect at the clock edge where `dm_we` is high.

Every arithmetic or logic result goes to AC. The other operand is a bank register or an 8-bit immediate. Ordinary instructions take a fetch cycle and an execute cycle. Indexed load and store add an address cycle and a data cycle. Subroutine calls and interrupts each keep a single saved return address in hardware. A load from memory is written into AC during the fetch of the next instruction.

The sequencer is a four-state machine:
- `ST_FETCH` always moves to `ST_EXEC`.
- `ST_EXEC` moves to `ST_IDX_ADDR` for an indexed access and to `ST_FETCH` for anything else.
- `ST_IDX_ADDR` moves to `ST_IDX_DATA`.
- `ST_IDX_DATA` moves to `ST_FETCH`.

An instruction boundary is the exit from `ST_EXEC` back to fetch, or the exit from `ST_IDX_DATA`. The PC changes only at a boundary, and an interrupt can be accepted only there.

Top module: `acc8_core`

## Requirements
- R1: A synchronous reset sets PC, AC, F, all sixteen registers and both saved return addresses to zero and clears the interrupt-active state. After reset the core fetches from address 0, and it never asserts `dm_we` while reset is held.
- R2: Instruction layout is op[15:12]. Long form carries addr[11:0]. Register form carries xop[11:8] and r2[3:0]. Immediate form carries xop[11:8] and d[7:0]. Register group op=6 uses xop 2..6 for add, sub, and, or, xor, computing AC = AC op R[r2], with results taken modulo 256.
- R3: Immediate group op=7 uses xop 1..5 for addi, subi, andi, ori, xori, computing AC = AC op d.
- R4: Compares write F and nothing else. The comparison is unsigned, between AC and the operand, and F is set to 1 when the relation holds. Register-group xop 7..11 compare against R[r2], and immediate-group xop 6..10 compare against d. In both groups the order is eq, lt, le, gt, ge.
- R5: The jumps use the long form. op=2 always jumps to addr. op=3 jumps when F=1 and op=4 jumps when F=0. A jump that is not taken continues at PC+1.
- R6: op=0 loads AC from data memory at addr. The loaded value is visible to the very next instruction. op=1 writes AC to data memory at addr.
- R7: Register-group xop 0 loads AC from data memory and xop 1 writes AC to data memory. The address is (R11 shifted left by 4) + R[r2], computed in 12 bits.
- R8: Immediate xop 0 loads d into AC. Register-group xop 12 copies AC into R[r2], xop 13 copies R[r2] into AC, xop 14 inverts every bit of AC, and xop 15 clears R[r2].
- R9: Each instruction spends one fetch cycle and one execute cycle. Indexed loads and stores spend two more cycles, for four in total.
- R10: op=5 saves PC+1 in a single return register and jumps to addr. op=8 with xop 0 jumps to the saved return address.
- R11: A high `irq` is accepted only at an instruction boundary, and only when no interrupt is active. Accepting it saves the next PC in an interrupt-return register, marks an interrupt active and jumps to address 0x001. While an interrupt is active, `irq` has no effect.
- R12: op=8 with xop 1 resumes at the saved interrupt-return address and clears the active state, so a later `irq` is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Level interrupt request |
| pm_addr | output | 12 | Program memory address (equals the PC) |
| pm_rdata | input | 16 | Program memory read data, one cycle after the address |
| dm_addr | output | 12 | Data memory address |
| dm_wdata | output | 8 | Data memory write data (AC) |
| dm_we | output | 1 | Data memory write enable |
| dm_rdata | input | 8 | Data memory read data, one cycle after the address |

## Verification
The assertions rely on the memories returning read data exactly one cycle after the address. They also rely on `irq` being a clean synchronous level and on `rst` being held high at the first clock edge. The bench meets all of these:
- Its memory models register reads on the same edge the core uses.
- It changes `rst` and `irq` only on falling edges.
- It starts every program with reset asserted.
- It holds `irq` high until the service routine has visibly started.

The single return and interrupt registers are never overwritten under test, because no program nests a call or re-enables interrupts inside a handler.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_IDX_ADDR,
        ST_IDX_DATA
    } seq_state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_PASS,
        ALU_NOT
    } alu_fn_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_LT,
        CMP_LE,
        CMP_GT,
        CMP_GE
    } cmp_fn_e;

    typedef enum logic [3:0] {
        K_NOP,
        K_LDA,
        K_STA,
        K_JMP,
        K_JT,
        K_JF,
        K_CALL,
        K_RET,
        K_RETI,
        K_ALU,
        K_CMP,
        K_MOV,
        K_CLR,
        K_LDX,
        K_STX
    } kind_e;

    typedef struct packed {
        kind_e   kind;
        alu_fn_e alu_fn;
        cmp_fn_e cmp_fn;
        logic    use_imm;
    } ctrl_t;

    // major opcodes
    localparam logic [3:0] OP_LDA  = 4'h0;
    localparam logic [3:0] OP_STA  = 4'h1;
    localparam logic [3:0] OP_JMP  = 4'h2;
    localparam logic [3:0] OP_JT   = 4'h3;
    localparam logic [3:0] OP_JF   = 4'h4;
    localparam logic [3:0] OP_CALL = 4'h5;
    localparam logic [3:0] OP_REG  = 4'h6;
    localparam logic [3:0] OP_IMM  = 4'h7;
    localparam logic [3:0] OP_SYS  = 4'h8;

    // register group
    localparam logic [3:0] XR_LDX = 4'h0;
    localparam logic [3:0] XR_STX = 4'h1;
    localparam logic [3:0] XR_ADD = 4'h2;
    localparam logic [3:0] XR_SUB = 4'h3;
    localparam logic [3:0] XR_AND = 4'h4;
    localparam logic [3:0] XR_OR  = 4'h5;
    localparam logic [3:0] XR_XOR = 4'h6;
    localparam logic [3:0] XR_EQ  = 4'h7;
    localparam logic [3:0] XR_LT  = 4'h8;
    localparam logic [3:0] XR_LE  = 4'h9;
    localparam logic [3:0] XR_GT  = 4'hA;
    localparam logic [3:0] XR_GE  = 4'hB;
    localparam logic [3:0] XR_MOV = 4'hC;
    localparam logic [3:0] XR_MVA = 4'hD;
    localparam logic [3:0] XR_NOT = 4'hE;
    localparam logic [3:0] XR_CLR = 4'hF;

    // immediate group
    localparam logic [3:0] XI_LCA = 4'h0;
    localparam logic [3:0] XI_ADD = 4'h1;
    localparam logic [3:0] XI_SUB = 4'h2;
    localparam logic [3:0] XI_AND = 4'h3;
    localparam logic [3:0] XI_OR  = 4'h4;
    localparam logic [3:0] XI_XOR = 4'h5;
    localparam logic [3:0] XI_EQ  = 4'h6;
    localparam logic [3:0] XI_LT  = 4'h7;
    localparam logic [3:0] XI_LE  = 4'h8;
    localparam logic [3:0] XI_GT  = 4'h9;
    localparam logic [3:0] XI_GE  = 4'hA;

    // system group
    localparam logic [3:0] XS_RET  = 4'h0;
    localparam logic [3:0] XS_RETI = 4'h1;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic [IW-1:0] instr,
    output ctrl_t         ctrl
);

    localparam int OP_HI  = IW - 1;
    localparam int XOP_HI = IW - 5;

    logic [3:0] op;
    logic [3:0] xop;

    assign op  = instr[OP_HI -: 4];
    assign xop = instr[XOP_HI -: 4];

    always_comb begin
        ctrl.kind    = K_NOP;
        ctrl.alu_fn  = ALU_PASS;
        ctrl.cmp_fn  = CMP_EQ;
        ctrl.use_imm = 1'b0;
        case (op)
            OP_LDA:  ctrl.kind = K_LDA;
            OP_STA:  ctrl.kind = K_STA;
            OP_JMP:  ctrl.kind = K_JMP;
            OP_JT:   ctrl.kind = K_JT;
            OP_JF:   ctrl.kind = K_JF;
            OP_CALL: ctrl.kind = K_CALL;
            OP_REG: begin
                case (xop)
                    XR_LDX: ctrl.kind = K_LDX;
                    XR_STX: ctrl.kind = K_STX;
                    XR_ADD: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_ADD; end
                    XR_SUB: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_SUB; end
                    XR_AND: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_AND; end
                    XR_OR:  begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_OR;  end
                    XR_XOR: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_XOR; end
                    XR_EQ:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_EQ;  end
                    XR_LT:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_LT;  end
                    XR_LE:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_LE;  end
                    XR_GT:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_GT;  end
                    XR_GE:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_GE;  end
                    XR_MOV: ctrl.kind = K_MOV;
                    XR_MVA: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_PASS; end
                    XR_NOT: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_NOT; end
                    XR_CLR: ctrl.kind = K_CLR;
                    default: ctrl.kind = K_NOP;
                endcase
            end
            OP_IMM: begin
                ctrl.use_imm = 1'b1;
                case (xop)
                    XI_LCA: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_PASS; end
                    XI_ADD: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_ADD; end
                    XI_SUB: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_SUB; end
                    XI_AND: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_AND; end
                    XI_OR:  begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_OR;  end
                    XI_XOR: begin ctrl.kind = K_ALU; ctrl.alu_fn = ALU_XOR; end
                    XI_EQ:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_EQ;  end
                    XI_LT:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_LT;  end
                    XI_LE:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_LE;  end
                    XI_GT:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_GT;  end
                    XI_GE:  begin ctrl.kind = K_CMP; ctrl.cmp_fn = CMP_GE;  end
                    default: ctrl.kind = K_NOP;
                endcase
            end
            OP_SYS: begin
                case (xop)
                    XS_RET:  ctrl.kind = K_RET;
                    XS_RETI: ctrl.kind = K_RETI;
                    default: ctrl.kind = K_NOP;
                endcase
            end
            default: ctrl.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_fn_e       fn,
    input  cmp_fn_e       cfn,
    output logic [DW-1:0] y,
    output logic          flag
);

    logic a_eq_b;
    logic a_lt_b;

    assign a_eq_b = (a == b);
    assign a_lt_b = (a < b);

    always_comb begin
        unique case (fn)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_PASS: y = b;
            ALU_NOT:  y = ~a;
            default:  y = b;
        endcase
    end

    always_comb begin
        unique case (cfn)
            CMP_EQ:  flag = a_eq_b;
            CMP_LT:  flag = a_lt_b;
            CMP_LE:  flag = a_lt_b | a_eq_b;
            CMP_GT:  flag = ~(a_lt_b | a_eq_b);
            CMP_GE:  flag = ~a_lt_b;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc8_regbank.sv
module acc8_regbank #(
    parameter  int DW     = 8,
    parameter  int NREG   = 16,
    parameter  int BP_IDX = 11,
    localparam int RAW    = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr,
    output logic [DW-1:0]  rdata,
    output logic [DW-1:0]  bp
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
    assign bp    = regs[BP_IDX];

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 12,
    parameter int IW       = 16,
    parameter int NREG     = 16,
    parameter int BP_IDX   = 11,
    parameter int BP_SHIFT = 4,
    parameter int IRQ_VEC  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    output logic [AW-1:0] pm_addr,
    input  logic [IW-1:0] pm_rdata,
    output logic [AW-1:0] dm_addr,
    output logic [DW-1:0] dm_wdata,
    output logic          dm_we,
    input  logic [DW-1:0] dm_rdata
);

    localparam int RAW = $clog2(NREG);
    localparam logic [AW-1:0] VEC = AW'(IRQ_VEC);

    seq_state_e    state;
    seq_state_e    state_nx;
    logic [AW-1:0] pc;
    logic [AW-1:0] pc_nx;
    logic [AW-1:0] ret_pc;
    logic [AW-1:0] int_ret;
    logic [AW-1:0] dar;
    logic [AW-1:0] ea;
    logic [DW-1:0] ac;
    logic          flag;
    logic          int_act;
    logic          ld_pend;
    logic [IW-1:0] ir_q;
    logic [IW-1:0] instr;
    ctrl_t         ctrl;

    logic [AW-1:0]  f_addr;
    logic [DW-1:0]  f_imm;
    logic [RAW-1:0] f_reg;

    logic [DW-1:0] rd_data;
    logic [DW-1:0] bp;
    logic [DW-1:0] operand;
    logic [DW-1:0] alu_y;
    logic          cmp_f;
    logic          rf_we;
    logic [DW-1:0] rf_wd;
    logic          boundary;
    logic          take_irq;

    // instruction source: live memory word in execute, latched word afterwards
    assign instr  = (state == ST_EXEC) ? pm_rdata : ir_q;
    assign f_addr = instr[AW-1:0];
    assign f_imm  = instr[DW-1:0];
    assign f_reg  = instr[RAW-1:0];

    acc8_decode #(.IW(IW)) u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    acc8_regbank #(.DW(DW), .NREG(NREG), .BP_IDX(BP_IDX)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (f_reg),
        .wdata (rf_wd),
        .raddr (f_reg),
        .rdata (rd_data),
        .bp    (bp)
    );

    assign operand = ctrl.use_imm ? f_imm : rd_data;

    acc8_alu #(.DW(DW)) u_alu (
        .a    (ac),
        .b    (operand),
        .fn   (ctrl.alu_fn),
        .cfn  (ctrl.cmp_fn),
        .y    (alu_y),
        .flag (cmp_f)
    );

    assign ea = (AW'(bp) << BP_SHIFT) + AW'(rd_data);

    assign rf_we = (state == ST_EXEC) && ((ctrl.kind == K_MOV) || (ctrl.kind == K_CLR));
    assign rf_wd = (ctrl.kind == K_MOV) ? ac : '0;

    assign boundary = ((state == ST_EXEC) && (ctrl.kind != K_LDX) && (ctrl.kind != K_STX))
                    || (state == ST_IDX_DATA);
    assign take_irq = boundary && irq && !int_act;

    // next program counter for the instruction being completed
    always_comb begin
        pc_nx = pc + AW'(1);
        if (state == ST_EXEC) begin
            case (ctrl.kind)
                K_JMP:   pc_nx = f_addr;
                K_CALL:  pc_nx = f_addr;
                K_JT:    if (flag)  pc_nx = f_addr;
                K_JF:    if (!flag) pc_nx = f_addr;
                K_RET:   pc_nx = ret_pc;
                K_RETI:  pc_nx = int_ret;
                default: pc_nx = pc + AW'(1);
            endcase
        end
    end

    // sequencer transitions
    always_comb begin
        unique case (state)
            ST_FETCH:    state_nx = ST_EXEC;
            ST_EXEC:     state_nx = ((ctrl.kind == K_LDX) || (ctrl.kind == K_STX))
                                    ? ST_IDX_ADDR : ST_FETCH;
            ST_IDX_ADDR: state_nx = ST_IDX_DATA;
            ST_IDX_DATA: state_nx = ST_FETCH;
            default:     state_nx = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // memory-side outputs
    always_comb begin
        pm_addr  = pc;
        dm_addr  = dar;
        dm_wdata = ac;
        dm_we    = 1'b0;
        unique case (state)
            ST_FETCH:    dm_addr = dar;
            ST_EXEC: begin
                if ((ctrl.kind == K_LDA) || (ctrl.kind == K_STA)) begin
                    dm_addr = f_addr;
                end
                dm_we = (ctrl.kind == K_STA);
            end
            ST_IDX_ADDR: dm_addr = dar;
            ST_IDX_DATA: dm_we = (ctrl.kind == K_STX);
            default:     dm_we = 1'b0;
        endcase
    end

    // architectural state
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ac      <= '0;
            flag    <= 1'b0;
            ret_pc  <= '0;
            int_ret <= '0;
            int_act <= 1'b0;
            ld_pend <= 1'b0;
            dar     <= '0;
            ir_q    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (ld_pend) begin
                        ac      <= dm_rdata;
                        ld_pend <= 1'b0;
                    end
                end
                ST_EXEC: begin
                    ir_q <= pm_rdata;
                    dar  <= ea;
                    case (ctrl.kind)
                        K_ALU:   ac      <= alu_y;
                        K_CMP:   flag    <= cmp_f;
                        K_LDA:   ld_pend <= 1'b1;
                        K_CALL:  ret_pc  <= pc + AW'(1);
                        K_RETI:  int_act <= 1'b0;
                        default: ;
                    endcase
                end
                ST_IDX_ADDR: ;
                ST_IDX_DATA: begin
                    if (ctrl.kind == K_LDX) begin
                        ac <= dm_rdata;
                    end
                end
                default: ;
            endcase
            if (take_irq) begin
                pc      <= VEC;
                int_ret <= pc_nx;
                int_act <= 1'b1;
            end else if (boundary) begin
                pc <= pc_nx;
            end
        end
    end

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
    import acc8_pkg::*;
#(
    parameter int AW      = 12,
    parameter int IRQ_VEC = 1
) (
    input logic          clk,
    input logic          rst,
    input seq_state_e    state,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] pm_addr,
    input logic          int_act,
    input logic          dm_we
);

    AST_RESET_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pm_addr == '0 && state == ST_FETCH && !dm_we)); // R1

    AST_EXEC_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |-> ($past(state) == ST_FETCH)); // R9

    AST_IDX_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDX_ADDR) |=> (state == ST_IDX_DATA)); // R9

    AST_IDX_DATA_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDX_DATA) |=> (state == ST_FETCH)); // R9

    AST_PC_MOVES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> (state == ST_FETCH)); // R9

    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> (state == ST_EXEC || state == ST_IDX_DATA)); // R6

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        $rose(int_act) |-> (pc == AW'(IRQ_VEC))); // R11

    AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(int_act) |-> (state == ST_FETCH)); // R11

endmodule

bind acc8_core acc8_core_chk #(.AW(AW), .IRQ_VEC(IRQ_VEC)) i_acc8_core_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .pc      (pc),
    .pm_addr (pm_addr),
    .int_act (int_act),
    .dm_we   (dm_we)
);

// File: tb/test_acc8_core.sv
module test_acc8_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [11:0] pm_addr;
    logic [15:0] pm_rdata;
    logic [11:0] dm_addr;
    logic [7:0]  dm_wdata;
    logic        dm_we;
    logic [7:0]  dm_rdata;

    logic [15:0] pm [MEM_N];
    logic [7:0]  dm [MEM_N];
    int          wtime [MEM_N];
    int          cyc = 0;
    logic        clr_req = 1'b0;
    logic        poke_en = 1'b0;
    logic [9:0]  poke_a = '0;
    logic [7:0]  poke_d = '0;

    int errors = 0;
    int checks = 0;
    int pa = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc8_core i_acc8_core (
        .clk      (clk),
        .rst      (rst),
        .irq      (irq),
        .pm_addr  (pm_addr),
        .pm_rdata (pm_rdata),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .dm_we    (dm_we),
        .dm_rdata (dm_rdata)
    );

    // synchronous memory models
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        pm_rdata <= pm[pm_addr[9:0]];
        dm_rdata <= dm[dm_addr[9:0]];
        if (clr_req) begin
            for (int i = 0; i < MEM_N; i++) begin
                dm[i]    <= 8'h00;
                wtime[i] <= -1;
            end
        end else if (poke_en) begin
            dm[poke_a] <= poke_d;
        end else if (dm_we) begin
            dm[dm_addr[9:0]]    <= dm_wdata;
            wtime[dm_addr[9:0]] <= cyc;
        end
    end

    function automatic logic [15:0] iL(input logic [3:0] op, input int a);
        return {op, 12'(a)};
    endfunction
    function automatic logic [15:0] iR(input logic [3:0] x, input int r);
        return {4'h6, x, 4'h0, 4'(r)};
    endfunction
    function automatic logic [15:0] iI(input logic [3:0] x, input int d);
        return {4'h7, x, 8'(d)};
    endfunction

    task automatic emit(input logic [15:0] w);
        pm[pa] = w;
        pa++;
    endtask

    task automatic halt();
        emit(iL(4'h2, pa));
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic new_prog();
        rst = 1'b1;
        for (int i = 0; i < MEM_N; i++) pm[i] = iL(4'h2, i);
        pa = 0;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic poke(input int a, input int d);
        poke_a  = 10'(a);
        poke_d  = 8'(d);
        poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int exp_op(input int k, input int a, input int b);
        case (k)
            0: return (a + b) & 255;
            1: return (a - b) & 255;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cmp(input int k, input int a, input int b);
        case (k)
            0: return int'(a == b);
            1: return int'(a < b);
            2: return int'(a <= b);
            3: return int'(a > b);
            default: return int'(a >= b);
        endcase
    endfunction

    int vals [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        new_prog();
        emit(iR(4'hD, 5));          // mva r5
        emit(iL(4'h1, 12'h200));    // sta
        halt();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pm_addr in reset", int'(pm_addr), 0);
        chk("R1 dm_we in reset", int'(dm_we), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first fetch address", int'(pm_addr), 0);
        repeat (10) @(negedge clk);
        chk("R1 register cleared", int'(dm[12'h200]), 0);

        // R2 R3 R4 R5: operand sweep
        foreach (vals[ia]) begin
            foreach (vals[ib]) begin
                int a;
                int b;
                a = vals[ia];
                b = vals[ib];
                new_prog();
                emit(iI(4'h0, b));
                emit(iR(4'hC, 1));
                for (int k = 0; k < 5; k++) begin
                    emit(iI(4'h0, a));
                    emit(iR(4'(2 + k), 1));
                    emit(iL(4'h1, 12'h100 + k));
                end
                for (int k = 0; k < 5; k++) begin
                    emit(iI(4'h0, a));
                    emit(iI(4'(1 + k), b));
                    emit(iL(4'h1, 12'h108 + k));
                end
                for (int k = 0; k < 10; k++) begin
                    emit(iI(4'h0, a));
                    if (k < 5) emit(iR(4'(7 + k), 1));
                    else       emit(iI(4'(6 + k - 5), b));
                    emit(iI(4'h0, 0));
                    emit(iL(4'h4, pa + 2));  // jf over the next word
                    emit(iI(4'h0, 1));
                    emit(iL(4'h1, 12'h110 + k));
                end
                halt();
                start();
                repeat (200) @(negedge clk);
                for (int k = 0; k < 5; k++) begin
                    chk("R2 register op", int'(dm[12'h100 + k]), exp_op(k, a, b));
                    chk("R3 immediate op", int'(dm[12'h108 + k]), exp_op(k, a, b));
                    chk("R4 R5 register compare", int'(dm[12'h110 + k]), exp_cmp(k, a, b));
                    chk("R4 R5 immediate compare", int'(dm[12'h115 + k]), exp_cmp(k, a, b));
                end
            end
        end

        // R6 R8 R5: moves, not, clr, direct load/store, jmp
        for (int t = 0; t < 4; t++) begin
            int x;
            x = (t * 8'h47 + 3) & 255;
            new_prog();
            poke(12'h2A0, x);
            emit(iI(4'h0, 8'h3C)); emit(iR(4'hE, 0)); emit(iL(4'h1, 12'h201));
            emit(iI(4'h0, 8'h99)); emit(iR(4'hC, 6)); emit(iI(4'h0, 0));
            emit(iR(4'hD, 6));     emit(iL(4'h1, 12'h202));
            emit(iR(4'hF, 6));     emit(iR(4'hD, 6)); emit(iL(4'h1, 12'h203));
            emit(iL(4'h0, 12'h2A0)); emit(iL(4'h1, 12'h204));
            emit(iL(4'h0, 12'h2A0)); emit(iI(4'h1, 1)); emit(iL(4'h1, 12'h205));
            emit(iL(4'h2, pa + 3));
            emit(iI(4'h0, 8'hEE)); emit(iL(4'h1, 12'h206));
            emit(iI(4'h0, 8'h77)); emit(iL(4'h1, 12'h207));
            halt();
            start();
            repeat (80) @(negedge clk);
            chk("R8 not", int'(dm[12'h201]), 8'hC3);
            chk("R8 mov/mva", int'(dm[12'h202]), 8'h99);
            chk("R8 clr", int'(dm[12'h203]), 0);
            chk("R6 lda then sta", int'(dm[12'h204]), x);
            chk("R6 lda then addi", int'(dm[12'h205]), (x + 1) & 255);
            chk("R5 jmp skipped store", int'(dm[12'h206]), 0);
            chk("R5 jmp target store", int'(dm[12'h207]), 8'h77);
        end

        // R7: indexed access
        foreach (vals[ib]) begin
            int base;
            int idx;
            int ea;
            base = (ib % 3 == 0) ? 0 : ((ib % 3 == 1) ? 1 : 8'h20);
            idx  = (ib < 3) ? 0 : ((ib < 6) ? 5 : 8'hFF);
            ea   = ((base << 4) + idx) & 12'hFFF;
            new_prog();
            poke(ea, base ^ idx ^ 8'h5A);
            emit(iI(4'h0, base)); emit(iR(4'hC, 11));
            emit(iI(4'h0, idx));  emit(iR(4'hC, 1));
            emit(iR(4'h0, 1));    emit(iL(4'h1, 12'h3D0));
            emit(iI(4'h0, 8'hA5 ^ idx)); emit(iR(4'h1, 1));
            halt();
            start();
            repeat (40) @(negedge clk);
            chk("R7 ldx value", int'(dm[12'h3D0]), (base ^ idx ^ 8'h5A) & 255);
            chk("R7 stx value", int'(dm[ea]), (8'hA5 ^ idx) & 255);
        end

        // R9: cycle counts
        new_prog();
        emit(iL(4'h1, 12'h3A0));
        emit(iI(4'h0, 1)); emit(iR(4'hD, 1)); emit(iR(4'hE, 0));
        emit(iL(4'h1, 12'h3A1));
        emit(iR(4'h0, 0));
        emit(iL(4'h1, 12'h3A2));
        emit(iR(4'h1, 0));
        emit(iL(4'h1, 12'h3A3));
        halt();
        start();
        repeat (40) @(negedge clk);
        chk("R9 two-cycle instructions", wtime[12'h3A1] - wtime[12'h3A0], 8);
        chk("R9 four-cycle ldx", wtime[12'h3A2] - wtime[12'h3A1], 6);
        chk("R9 four-cycle stx write", wtime[0] - wtime[12'h3A2], 4);
        chk("R9 after stx", wtime[12'h3A3] - wtime[0], 2);

        // R10: call and return
        new_prog();
        emit(iL(4'h5, 12'h040)); emit(iI(4'h0, 8'h33)); emit(iL(4'h1, 12'h3C1));
        halt();
        pa = 12'h040;
        emit(iI(4'h0, 8'h22)); emit(iL(4'h1, 12'h3C0)); emit({4'h8, 4'h0, 8'h00});
        start();
        repeat (40) @(negedge clk);
        chk("R10 subroutine ran", int'(dm[12'h3C0]), 8'h22);
        chk("R10 returned to caller", int'(dm[12'h3C1]), 8'h33);
        chk("R10 order", int'(wtime[12'h3C0] < wtime[12'h3C1]), 1);

        // R11 R12: interrupt entry, no nesting, resume
        new_prog();
        emit(iL(4'h2, 12'h010));
        emit(iL(4'h0, 12'h3E0)); emit(iI(4'h1, 1)); emit(iL(4'h1, 12'h3E0));
        emit(iI(4'h0, 8'h5A));   emit(iL(4'h1, 12'h3F0));
        emit({4'h8, 4'h1, 8'h00});
        pa = 12'h010;
        for (int k = 0; k < 16; k++) begin
            emit(iI(4'h0, 8'h40 + k));
            emit(iL(4'h1, 12'h380 + k));
        end
        halt();
        start();
        repeat (12) @(negedge clk);
        irq = 1'b1;
        for (int t = 0; t < 200 && dm[12'h3F0] != 8'h5A; t++) @(negedge clk);
        irq = 1'b0;
        repeat (120) @(negedge clk);
        chk("R11 handler at vector ran", int'(dm[12'h3F0]), 8'h5A);
        chk("R11 no nested entry", int'(dm[12'h3E0]), 1);
        for (int k = 0; k < 16; k++) begin
            chk("R12 interrupted program resumed", int'(dm[12'h380 + k]), 8'h40 + k);
        end
        irq = 1'b1;
        for (int t = 0; t < 200 && dm[12'h3E0] != 8'h02; t++) @(negedge clk);
        irq = 1'b0;
        repeat (40) @(negedge clk);
        chk("R12 re-enabled after return", int'(dm[12'h3E0]), 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule